// File: doc/BRIEF.md
# Double-Buffered Transmit Endpoint Store

This block holds outgoing packets for one bulk, interrupt or isochronous transmit endpoint. It has two packet banks. A local writer, either a microcontroller or a DMA engine, fills one bank while the USB transmit side drains the other. Each bank has a full flag. The writer raises that flag with a validate pulse, with an end-of-transfer pulse from the DMA engine, or automatically when the payload reaches the maximum packet size of the current endpoint configuration. The transmit side clears the flag with a done pulse once the packet has gone out. Both sides switch banks on their own, so software never chooses a bank.

A microcontroller write stream starts with two header bytes: a reserved byte, then a length byte. Neither header byte is stored. A DMA stream carries payload only. In both cases the packet length reported to the transmit side is the number of payload bytes the block counted. The transmit side reads the packet bytes by address. It also receives the data toggle to send, which alternates with every packet that completes. A flush pulse reinitialises the endpoint: it drops all buffered data, resets both bank pointers to the first bank and resets the toggle to DATA0.

Top module: `pp_in_ep_buffer`

## Requirements
- R1: After reset both banks are empty, `usb_ready`, `not_empty`, `usb_data1`, `overflow` are 0 and `buf_status` is 00h.
- R2: On the microcontroller path (`wr_dma`=0) the first two accepted bytes of a packet (reserved, length) are not stored; the following bytes are stored from address 0, and `usb_len` equals the number of those payload bytes.
- R3: On the DMA path (`wr_dma`=1) every accepted byte is payload, stored from address 0 upward.
- R4: A `validate` pulse marks the local bank full with its current payload count (zero allowed), and the next packet goes to the other bank.
- R5: A bank is marked full automatically when its payload count reaches the maximum packet size: the small size for `cfg_mode` 0 and 3, the large size for `cfg_mode` 1 and 2. The packet is not marked full one byte earlier.
- R6: A `dma_eot` pulse marks the local bank full like `validate`; a byte written in the same cycle is included in the packet.
- R7: The transmit side always sees the oldest full bank. A `usb_done` pulse while `usb_ready`=1 empties that bank and moves the transmit side to the other bank. A `usb_done` pulse while `usb_ready`=0 has no effect.
- R8: While the local bank is still full (both banks full), writes, `validate` and `dma_eot` are ignored, and each dropped write sets `overflow`, which stays set until a flush.
- R9: `usb_data1` starts at 0 (DATA0) and inverts on every effective `usb_done`.
- R10: A `flush` pulse empties both banks, discards a partly written packet, clears `overflow` and `usb_data1`, and makes the first bank the next one used on both sides.
- R11: `buf_status` bit 5 is the first bank's full flag, bit 6 is the second bank's full flag, and all other bits are 0. `not_empty` is 1 when either bank is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Endpoint configuration mode; selects the maximum packet size |
| flush | input | 1 | Reinitialise the endpoint (stall cleared) |
| wr_valid | input | 1 | Write strobe from the local side |
| wr_dma | input | 1 | 1: the write is a DMA payload byte; 0: the write is a microcontroller stream byte |
| wr_data | input | 8 | Write data |
| validate | input | 1 | Validate command: mark the local bank full |
| dma_eot | input | 1 | DMA end of transfer: mark the local bank full |
| usb_rd_addr | input | AW | Byte address inside the bank being transmitted |
| usb_rd_data | output | 8 | Byte at `usb_rd_addr` of the bank being transmitted |
| usb_done | input | 1 | Packet sent: free the bank being transmitted |
| usb_ready | output | 1 | The bank being transmitted is full |
| usb_len | output | CNT_W | Payload length of the bank being transmitted |
| usb_data1 | output | 1 | Data toggle for the next packet (1 = DATA1) |
| ping_full | output | 1 | First bank full |
| pong_full | output | 1 | Second bank full |
| not_empty | output | 1 | Either bank full |
| buf_status | output | 8 | Status byte with the bank full flags in bits 5 and 6 |
| overflow | output | 1 | Sticky: a write was dropped since the last flush |

## Verification
The bench builds the block with a small maximum packet size of 8 and a large one of 16, so AW is 4 and CNT_W is 5. These sizes let it sweep every microcontroller packet length from 0 up to one below the limit. They also let it cross the automatic-commit boundary in all four configuration modes within a few hundred cycles. It follows the bank pointers, full flags and toggle through the sequence of commits and completions it drives. This covers both-full blocking, dropped validates and end-of-transfer pulses, and a flush that lands in the middle of a packet.

// File: rtl/pp_pkg.sv
package pp_pkg;

    // Position inside a microcontroller write stream
    typedef enum logic [1:0] {
        PH_RSV = 2'd0,  // reserved header byte expected
        PH_LEN = 2'd1,  // length header byte expected
        PH_PAY = 2'd2   // payload bytes
    } fill_phase_e;

    // Bit positions of the bank full flags in the status byte
    localparam int unsigned STAT_BANK0_BIT = 5;
    localparam int unsigned STAT_BANK1_BIT = 6;

endpackage

// File: rtl/pp_bank_store.sv
module pp_bank_store #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 128,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wsel,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rsel,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned NBANK = 2;

    logic [DW-1:0] rd_word [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DW-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (wsel == 1'(b))) begin
                mem_q[waddr] <= wdata;
            end
        end

        assign rd_word[b] = mem_q[raddr];
    end

    assign rdata = rd_word[rsel];

endmodule

// File: rtl/pp_fill_ctrl.sv
module pp_fill_ctrl
    import pp_pkg::*;
#(
    parameter int unsigned DW        = 8,
    parameter int unsigned MPS_LARGE = 128,
    parameter int unsigned AW        = $clog2(MPS_LARGE),
    parameter int unsigned CNT_W     = $clog2(MPS_LARGE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             blocked,
    input  logic [CNT_W-1:0] mps,
    input  logic             wr_valid,
    input  logic             wr_dma,
    input  logic [DW-1:0]    wr_data,
    input  logic             validate,
    input  logic             dma_eot,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_data,
    output logic             commit,
    output logic [CNT_W-1:0] commit_len,
    output logic             drop
);

    typedef struct packed {
        fill_phase_e      phase;
        logic [CNT_W-1:0] cnt;
    } fill_t;

    fill_t            f_d, f_q;
    logic             accept;
    logic [CNT_W-1:0] cnt_after;

    always_comb begin
        f_d        = f_q;
        accept     = wr_valid && !blocked && !flush;
        drop       = wr_valid && blocked;
        mem_we     = accept && (wr_dma || (f_q.phase == PH_PAY));
        mem_addr   = f_q.cnt[AW-1:0];
        mem_data   = wr_data;
        cnt_after  = f_q.cnt + CNT_W'(mem_we);
        commit_len = cnt_after;
        commit     = !blocked && !flush &&
                     (validate || dma_eot || (mem_we && (cnt_after == mps)));

        if (flush || commit) begin
            f_d.phase = PH_RSV;
            f_d.cnt   = '0;
        end else if (accept) begin
            f_d.cnt = cnt_after;
            if (!wr_dma) begin
                unique case (f_q.phase)
                    PH_RSV:  f_d.phase = PH_LEN;
                    PH_LEN:  f_d.phase = PH_PAY;
                    default: f_d.phase = PH_PAY;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{phase: PH_RSV, cnt: '0};
        end else begin
            f_q <= f_d;
        end
    end

    // R5: a packet is always committed before its count can pass the largest size
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt < CNT_W'(MPS_LARGE));

    // R2: a stream write in a header phase never advances the payload count
    assert_hdr_not_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_dma && !blocked && !flush && !commit && (f_q.phase != PH_PAY))
        |=> $stable(f_q.cnt));

endmodule

// File: rtl/pp_in_ep_buffer.sv
module pp_in_ep_buffer
    import pp_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MPS_SMALL = 64,
    parameter int unsigned MPS_LARGE = 128,
    localparam int unsigned AW       = $clog2(MPS_LARGE),
    localparam int unsigned CNT_W    = $clog2(MPS_LARGE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              flush,
    input  logic              wr_valid,
    input  logic              wr_dma,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              validate,
    input  logic              dma_eot,
    input  logic [AW-1:0]     usb_rd_addr,
    output logic [DATA_W-1:0] usb_rd_data,
    input  logic              usb_done,
    output logic              usb_ready,
    output logic [CNT_W-1:0]  usb_len,
    output logic              usb_data1,
    output logic              ping_full,
    output logic              pong_full,
    output logic              not_empty,
    output logic [7:0]        buf_status,
    output logic              overflow
);

    typedef struct packed {
        logic [1:0]            full;
        logic [1:0][CNT_W-1:0] len;
        logic                  lp;    // bank the local side fills
        logic                  up;    // bank the USB side drains
        logic                  tog;
        logic                  ovf;
    } ctl_t;

    ctl_t             c_d, c_q;
    logic [CNT_W-1:0] mps;
    logic             blocked;
    logic             mem_we;
    logic [AW-1:0]    mem_addr;
    logic [DATA_W-1:0] mem_data;
    logic             commit;
    logic [CNT_W-1:0] commit_len;
    logic             drop;
    logic             usb_take;

    assign mps      = ((cfg_mode == 2'd1) || (cfg_mode == 2'd2)) ? CNT_W'(MPS_LARGE)
                                                                 : CNT_W'(MPS_SMALL);
    assign blocked  = c_q.full[c_q.lp];
    assign usb_take = usb_done && c_q.full[c_q.up];

    pp_fill_ctrl #(
        .DW        (DATA_W),
        .MPS_LARGE (MPS_LARGE),
        .AW        (AW),
        .CNT_W     (CNT_W)
    ) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .blocked    (blocked),
        .mps        (mps),
        .wr_valid   (wr_valid),
        .wr_dma     (wr_dma),
        .wr_data    (wr_data),
        .validate   (validate),
        .dma_eot    (dma_eot),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .commit     (commit),
        .commit_len (commit_len),
        .drop       (drop)
    );

    pp_bank_store #(
        .DW    (DATA_W),
        .DEPTH (MPS_LARGE),
        .AW    (AW)
    ) u_store (
        .clk   (clk),
        .we    (mem_we),
        .wsel  (c_q.lp),
        .waddr (mem_addr),
        .wdata (mem_data),
        .rsel  (c_q.up),
        .raddr (usb_rd_addr),
        .rdata (usb_rd_data)
    );

    always_comb begin
        c_d = c_q;
        if (commit) begin
            c_d.full[c_q.lp] = 1'b1;
            c_d.len[c_q.lp]  = commit_len;
            c_d.lp           = ~c_q.lp;
        end
        if (usb_take) begin
            c_d.full[c_q.up] = 1'b0;
            c_d.up           = ~c_q.up;
            c_d.tog          = ~c_q.tog;
        end
        if (drop) begin
            c_d.ovf = 1'b1;
        end
        if (flush) begin
            c_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign usb_ready  = c_q.full[c_q.up];
    assign usb_len    = c_q.len[c_q.up];
    assign usb_data1  = c_q.tog;
    assign ping_full  = c_q.full[0];
    assign pong_full  = c_q.full[1];
    assign not_empty  = |c_q.full;
    assign overflow   = c_q.ovf;

    always_comb begin
        buf_status                 = '0;
        buf_status[STAT_BANK0_BIT] = c_q.full[0];
        buf_status[STAT_BANK1_BIT] = c_q.full[1];
    end

    // R7: a completed packet frees the bank it came from
    assert_done_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_take && !flush) |=> !c_q.full[$past(c_q.up)]);

    // R8: nothing is written into a bank that still holds a packet
    assert_no_write_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !c_q.full[c_q.lp]);

    // R8: a dropped write leaves the overflow flag set
    assert_drop_sets_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !flush) |=> c_q.ovf);

    // R9: the toggle only moves on a completion or a flush
    assert_toggle_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_q.tog) |-> ($past(usb_done) || $past(flush)));

    // R10: a flush leaves the endpoint empty with DATA0 and no overflow
    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (c_q.full == 2'b00) && !c_q.tog && !c_q.ovf && !c_q.lp && !c_q.up);

endmodule

// File: tb/sim_pp_in_ep_buffer.sv
module sim_pp_in_ep_buffer;

    localparam int SMALL = 8;
    localparam int LARGE = 16;
    localparam int AW    = $clog2(LARGE);
    localparam int CW    = $clog2(LARGE + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic          flush = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_dma = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic          validate = 1'b0;
    logic          dma_eot = 1'b0;
    logic [AW-1:0] usb_rd_addr = '0;
    logic [7:0]    usb_rd_data;
    logic          usb_done = 1'b0;
    logic          usb_ready;
    logic [CW-1:0] usb_len;
    logic          usb_data1;
    logic          ping_full;
    logic          pong_full;
    logic          not_empty;
    logic [7:0]    buf_status;
    logic          overflow;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // bench model of pointers and flags, driven by the events the bench causes
    bit       lp_m = 1'b0;
    bit       up_m = 1'b0;
    bit [1:0] full_m = 2'b00;
    bit       tog_m = 1'b0;

    always #5 clk = ~clk;

    pp_in_ep_buffer #(.DATA_W(8), .MPS_SMALL(SMALL), .MPS_LARGE(LARGE)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .flush(flush),
        .wr_valid(wr_valid), .wr_dma(wr_dma), .wr_data(wr_data),
        .validate(validate), .dma_eot(dma_eot),
        .usb_rd_addr(usb_rd_addr), .usb_rd_data(usb_rd_data),
        .usb_done(usb_done), .usb_ready(usb_ready), .usb_len(usb_len),
        .usb_data1(usb_data1), .ping_full(ping_full), .pong_full(pong_full),
        .not_empty(not_empty), .buf_status(buf_status), .overflow(overflow)
    );

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 17 + i * 3 + 1) & 255);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input logic dma, input logic eot);
        wr_valid = 1'b1; wr_data = b; wr_dma = dma; dma_eot = eot;
        tick();
        wr_valid = 1'b0; dma_eot = 1'b0;
    endtask

    task automatic do_validate();
        validate = 1'b1; tick(); validate = 1'b0;
    endtask

    task automatic do_eot();
        dma_eot = 1'b1; tick(); dma_eot = 1'b0;
    endtask

    task automatic do_done();
        usb_done = 1'b1; tick(); usb_done = 1'b0;
    endtask

    task automatic note_commit();
        full_m[lp_m] = 1'b1; lp_m = ~lp_m;
    endtask

    task automatic note_done();
        full_m[up_m] = 1'b0; up_m = ~up_m; tog_m = ~tog_m;
    endtask

    task automatic chk_status(input string tag);
        chk({tag, " status byte"}, int'(buf_status), int'({1'b0, full_m[1], full_m[0], 5'b0}));
        chk({tag, " not_empty"}, int'(not_empty), int'(|full_m));
        chk({tag, " ping_full"}, int'(ping_full), int'(full_m[0]));
    endtask

    task automatic chk_payload(input string tag, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            usb_rd_addr = AW'(i);
            #1;
            chk(tag, int'(usb_rd_data), int'(pat(seed, i)));
        end
    endtask

    task automatic dma_packet(input int n, input int seed);
        for (int i = 0; i < n; i++) put(pat(seed, i), 1'b1, 1'b0);
        do_validate();
        note_commit();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 usb_ready", int'(usb_ready), 0);
        chk("R1 data1", int'(usb_data1), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk_status("R1");

        // R2 R4 R7 R9 R11: microcontroller stream, every length below the small limit
        cfg_mode = 2'd0;
        for (int n = 0; n < SMALL; n++) begin
            put(8'h00, 1'b0, 1'b0);
            put(8'(n), 1'b0, 1'b0);
            for (int i = 0; i < n; i++) put(pat(n, i), 1'b0, 1'b0);
            chk("R4 not full before validate", int'(usb_ready), 0);
            do_validate();
            note_commit();
            chk("R4 ready after validate", int'(usb_ready), 1);
            chk_status("R11 after validate");
            chk("R2 length counted", int'(usb_len), n);
            chk_payload("R2 payload", n, n);
            chk("R9 toggle", int'(usb_data1), int'(tog_m));
            do_done();
            note_done();
            chk("R7 freed", int'(usb_ready), 0);
            chk_status("R7 after done");
            chk("R9 toggle after done", int'(usb_data1), int'(tog_m));
        end

        // R3 R5: DMA fill up to the limit of every mode
        for (int m = 0; m < 4; m++) begin
            int mps;
            cfg_mode = 2'(m);
            mps = ((m == 1) || (m == 2)) ? LARGE : SMALL;
            for (int i = 0; i < mps - 1; i++) put(pat(m + 20, i), 1'b1, 1'b0);
            chk("R5 no commit below limit", int'(usb_ready), 0);
            put(pat(m + 20, mps - 1), 1'b1, 1'b0);
            note_commit();
            chk("R5 auto commit at limit", int'(usb_ready), 1);
            chk("R5 length at limit", int'(usb_len), mps);
            chk_payload("R3 dma payload", mps, m + 20);
            do_done();
            note_done();
        end

        // R5: microcontroller stream also commits at the limit
        cfg_mode = 2'd3;
        put(8'h00, 1'b0, 1'b0);
        put(8'(SMALL), 1'b0, 1'b0);
        for (int i = 0; i < SMALL; i++) put(pat(30, i), 1'b0, 1'b0);
        note_commit();
        chk("R5 stream auto commit", int'(usb_ready), 1);
        chk("R5 stream length", int'(usb_len), SMALL);
        chk_payload("R2 stream payload at limit", SMALL, 30);
        do_done();
        note_done();

        // R6: end of transfer with and without a byte in the same cycle
        cfg_mode = 2'd0;
        put(pat(31, 0), 1'b1, 1'b0);
        put(pat(31, 1), 1'b1, 1'b0);
        put(pat(31, 2), 1'b1, 1'b1);
        note_commit();
        chk("R6 eot with byte", int'(usb_len), 3);
        chk("R6 ready", int'(usb_ready), 1);
        chk_payload("R6 payload", 3, 31);
        do_done();
        note_done();
        put(pat(32, 0), 1'b1, 1'b0);
        put(pat(32, 1), 1'b1, 1'b0);
        do_eot();
        note_commit();
        chk("R6 eot alone", int'(usb_len), 2);
        do_done();
        note_done();

        // R8: both banks full
        dma_packet(2, 40);
        dma_packet(3, 41);
        chk_status("R8 both full");
        chk("R8 overflow clear", int'(overflow), 0);
        put(8'h55, 1'b1, 1'b0);
        chk("R8 overflow set", int'(overflow), 1);
        do_validate();
        do_eot();
        chk_status("R8 validate and eot ignored");
        chk("R7 oldest first", int'(usb_len), 2);
        chk_payload("R8 first packet intact", 2, 40);
        do_done();
        note_done();
        chk("R7 second bank length", int'(usb_len), 3);
        chk_payload("R8 dropped byte not stored", 3, 41);
        put(pat(42, 0), 1'b1, 1'b1);
        note_commit();
        chk_status("R8 freed bank refilled");
        chk("R8 overflow sticky", int'(overflow), 1);
        do_done();
        note_done();
        chk("R7 third packet length", int'(usb_len), 1);
        chk_payload("R7 third packet", 1, 42);
        do_done();
        note_done();
        do_done();
        chk("R7 idle done ignored", int'(usb_data1), int'(tog_m));
        chk_status("R7 idle done");

        // R10: flush in the middle of traffic
        if (!tog_m) begin
            dma_packet(1, 43);
            do_done();
            note_done();
        end
        dma_packet(2, 44);
        put(pat(45, 0), 1'b1, 1'b0);
        put(pat(45, 1), 1'b1, 1'b0);
        chk("R10 toggle before flush", int'(usb_data1), 1);
        flush = 1'b1; tick(); flush = 1'b0;
        lp_m = 1'b0; up_m = 1'b0; full_m = 2'b00; tog_m = 1'b0;
        chk_status("R10 after flush");
        chk("R10 overflow cleared", int'(overflow), 0);
        chk("R10 DATA0 after flush", int'(usb_data1), 0);
        dma_packet(2, 46);
        chk("R10 first bank used", int'(buf_status), 8'h20);
        chk("R10 partial discarded", int'(usb_len), 2);
        chk_payload("R10 payload from zero", 2, 46);
        do_done();
        note_done();
        chk("R9 toggle after flush", int'(usb_data1), 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule